// File: doc/BRIEF.md
# Banked Program Counter with Interrupt Service

This block is the instruction address generator for a small 8-bit controller. Its program space is 4K words, seen as two 2K halves, and the top bit of the 12-bit counter chooses the half. One command arrives on each clock. The command can step the counter, arm a bank choice, branch, call, return, or enter or leave interrupt service. The result appears on the fetch address output after the next rising edge.

A bank-select command does not move the counter. It only sets or clears a pending-bank flag. The flag reaches bit 11 at the next branch or call, so software can arm the switch well before the branch that crosses the boundary. Calls and interrupt entries save the whole 12-bit address in an internal circular return stack. Plain returns restore it and leave the pending flag as it was.

A two-state machine tracks interrupt service. Its states are `ST_RUN` and `ST_SERVICE`. The transition `TAKE` goes from `ST_RUN` to `ST_SERVICE` on an interrupt entry command. The transition `LEAVE` goes from `ST_SERVICE` to `ST_RUN` on the return-from-interrupt command. Every other command keeps the current state. While in `ST_SERVICE`, branches land in bank 0 no matter what the pending flag holds, so bit 11 of the fetch address stays 0.

Command codes on `cmd_i`: 4'h0 hold, 4'h1 step, 4'h2 arm bank 0, 4'h3 arm bank 1, 4'h4 jump, 4'h5 call, 4'h6 return, 4'h7 return-from-interrupt, 4'h8 interrupt entry. Any other code acts as hold.

Top module: `banked_pc`

## Requirements
- R1: While `rst_n` is low, and after it is released, the fetch address is 12'h000, the pending-bank flag is clear and the state is `ST_RUN`. A jump (4'h4) right after reset therefore lands in bank 0, and an interrupt entry (4'h8) is taken.
- R2: Step (4'h1) adds one to bits 10:0 and wraps from 11'h7FF to 11'h000. Bit 11 keeps its value.
- R3: Arm bank 1 (4'h3) sets the pending flag and arm bank 0 (4'h2) clears it. Neither command changes the fetch address.
- R4: Jump (4'h4) outside service loads bits 10:0 from `target_i` and bit 11 from the pending flag.
- R5: Call (4'h5) branches in the same way as jump. It pushes the 12-bit address of the next instruction: the current address stepped by the R2 rule, with bit 11 kept.
- R6: Return (4'h6) pops and restores all 12 bits. It leaves the pending flag unchanged.
- R7: Interrupt entry (4'h8) in `ST_RUN` pushes the current 12-bit address and goes to 12'h003 when `irq_src_i` is 0, or to 12'h007 when it is 1. It takes the `TAKE` transition.
- R8: In `ST_SERVICE`, bit 11 of the fetch address is 0. This holds even after arm bank 1 followed by a jump or call. Those arm commands still update the pending flag, and the update shows at the first branch after service ends.
- R9: Interrupt entry (4'h8) in `ST_SERVICE` is ignored. The address does not change and nothing is pushed.
- R10: Return-from-interrupt (4'h7) pops and restores all 12 bits and takes `LEAVE` back to `ST_RUN`.
- R11: The return stack holds 8 entries and wraps circularly. After nine pushes the ninth entry has overwritten the first. Nine pops then give the ninth push, the eighth down to the second, and then the ninth push again.
- R12: Hold (4'h0) and unused codes leave the fetch address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 4 | Command code for this cycle |
| target_i | input | 11 | Branch target within a bank, used by jump and call |
| irq_src_i | input | 1 | Interrupt source: 0 vectors to 3, 1 vectors to 7 |
| fetch_addr_o | output | 12 | Current program fetch address |

## Verification
Every result is registered once. A command applied before rising edge N shows on `fetch_addr_o` after that edge, and returns and ignored commands follow the same rule. The bench changes inputs on the falling edge and applies one command per cycle. It reads the address on the next falling edge, so each check falls exactly one edge after its stimulus. The pending flag and the service state have no port of their own. They are checked through the address that a later jump or interrupt produces.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    typedef enum logic [3:0] {
        CMD_HOLD  = 4'h0,
        CMD_STEP  = 4'h1,
        CMD_ARM0  = 4'h2,
        CMD_ARM1  = 4'h3,
        CMD_JUMP  = 4'h4,
        CMD_CALL  = 4'h5,
        CMD_RET   = 4'h6,
        CMD_RETI  = 4'h7,
        CMD_IRQ   = 4'h8
    } cmd_e;

    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_SERVICE = 1'b1
    } svc_state_e;

endpackage

// File: rtl/bpc_bank_latch.sv
module bpc_bank_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic arm0_i,
    input  logic arm1_i,
    output logic pend_o
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (arm1_i) begin
            pend_q <= 1'b1;
        end else if (arm0_i) begin
            pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    p_arm1_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arm1_i |=> pend_o);
    p_arm0_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arm0_i && !arm1_i) |=> !pend_o);
endmodule

// File: rtl/bpc_ret_stack.sv
module bpc_ret_stack #(
    parameter int WIDTH = 12,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] push_data_i,
    output logic [WIDTH-1:0] top_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] sp_dec;

    // circular: decrement below zero wraps to the last slot
    always_comb begin
        sp_dec = (sp_q == '0) ? LAST : sp_q - PTR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (push_i) begin
            sp_q <= (sp_q == LAST) ? '0 : sp_q + PTR_W'(1);
        end else if (pop_i) begin
            sp_q <= sp_dec;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) begin
            mem_q[sp_q] <= push_data_i;
        end
    end

    assign top_o = mem_q[sp_dec];

    p_push_wraps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && sp_q == LAST) |=> (sp_q == '0));
    p_pop_wraps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && sp_q == '0) |=> (sp_q == LAST));
    p_no_dual_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));
endmodule

// File: rtl/bpc_svc_fsm.sv
module bpc_svc_fsm
    import bpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enter_i,
    input  logic leave_i,
    output logic in_svc_o
);
    svc_state_e state_q;
    svc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (enter_i) state_d = ST_SERVICE;   // TAKE
            end
            ST_SERVICE: begin
                if (leave_i) state_d = ST_RUN;       // LEAVE
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_SERVICE: in_svc_o = 1'b1;
            default:    in_svc_o = 1'b0;
        endcase
    end

    p_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && enter_i) |=> (state_q == ST_SERVICE));
    p_leave_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVICE && leave_i) |=> (state_q == ST_RUN));
endmodule

// File: rtl/banked_pc.sv
module banked_pc
    import bpc_pkg::*;
#(
    parameter int LOW_W       = 11,
    parameter int STACK_DEPTH = 8,
    parameter int VEC_LO      = 3,
    parameter int VEC_HI      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cmd_i,
    input  logic [LOW_W-1:0] target_i,
    input  logic             irq_src_i,
    output logic [LOW_W:0]   fetch_addr_o
);
    localparam int ADDR_W = LOW_W + 1;
    localparam int BANK   = LOW_W;

    cmd_e              cmd;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;
    logic [ADDR_W-1:0] pc_step;
    logic [ADDR_W-1:0] stack_top;
    logic [ADDR_W-1:0] push_data;
    logic              push;
    logic              pop;
    logic              pend;
    logic              in_svc;
    logic              take_irq;
    logic              branch_bank;

    assign cmd = cmd_e'(cmd_i);

    bpc_bank_latch u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm0_i (cmd == CMD_ARM0),
        .arm1_i (cmd == CMD_ARM1),
        .pend_o (pend)
    );

    bpc_svc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter_i  (take_irq),
        .leave_i  (cmd == CMD_RETI),
        .in_svc_o (in_svc)
    );

    bpc_ret_stack #(
        .WIDTH (ADDR_W),
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (push_data),
        .top_o       (stack_top)
    );

    assign take_irq    = (cmd == CMD_IRQ) && !in_svc;
    assign branch_bank = pend && !in_svc;
    assign pc_step     = {pc_q[BANK], pc_q[LOW_W-1:0] + LOW_W'(1)};

    always_comb begin
        pc_d      = pc_q;
        push      = 1'b0;
        pop       = 1'b0;
        push_data = pc_step;
        unique case (cmd)
            CMD_STEP: pc_d = pc_step;
            CMD_JUMP: pc_d = {branch_bank, target_i};
            CMD_CALL: begin
                pc_d = {branch_bank, target_i};
                push = 1'b1;
            end
            CMD_RET, CMD_RETI: begin
                pc_d = stack_top;
                pop  = 1'b1;
            end
            CMD_IRQ: begin
                if (take_irq) begin
                    pc_d      = {1'b0, (irq_src_i ? LOW_W'(VEC_HI) : LOW_W'(VEC_LO))};
                    push      = 1'b1;
                    push_data = pc_q;
                end
            end
            default: pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign fetch_addr_o = pc_q;

    p_step_keeps_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP) |=> (fetch_addr_o[BANK] == $past(fetch_addr_o[BANK]) &&
            fetch_addr_o[LOW_W-1:0] == LOW_W'($past(fetch_addr_o[LOW_W-1:0]) + LOW_W'(1))));
    p_arm_no_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ARM0 || cmd == CMD_ARM1) |=> $stable(fetch_addr_o));
    p_jump_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_JUMP && !in_svc) |=>
            (fetch_addr_o == {$past(pend), $past(target_i)}));
    p_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_IRQ && !in_svc) |=>
            (fetch_addr_o == ($past(irq_src_i) ? ADDR_W'(VEC_HI) : ADDR_W'(VEC_LO))));
    p_service_bank0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_svc |-> (fetch_addr_o[BANK] == 1'b0));
    p_irq_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_IRQ && in_svc) |=> $stable(fetch_addr_o));
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'h0 || cmd_i > 4'h8) |=> $stable(fetch_addr_o));
endmodule

// File: tb/banked_pc_tb.sv
`timescale 1ns/1ps
module banked_pc_tb;
    import bpc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cmd = 4'h0;
    logic [10:0] tgt = '0;
    logic        src = 1'b0;
    logic [11:0] fa;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    banked_pc u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_i        (cmd),
        .target_i     (tgt),
        .irq_src_i    (src),
        .fetch_addr_o (fa)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: cycles=%0d expected fewer than 100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [11:0] exp);
        checks++;
        if (fa !== exp) begin
            errors++;
            $display("FAIL %s: fetch_addr=%h expected %h", req, fa, exp);
        end
    endtask

    // drive at falling edge, one rising edge, read at next falling edge
    task automatic run(input logic [3:0] c, input logic [10:0] t, input logic s);
        cmd = c; tgt = t; src = s;
        @(posedge clk);
        @(negedge clk);
        cmd = 4'h0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cmd = 4'h0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset addr", 12'h000);
        run(4'h4, 11'h123, 0); chk("R1 pending clear after reset", 12'h123);
    endtask

    task automatic t_step();
        run(4'h4, 11'h7FE, 0);
        run(4'h1, 0, 0); chk("R2 step", 12'h7FF);
        run(4'h1, 0, 0); chk("R2 wrap bank0", 12'h000);
        run(4'h3, 0, 0);
        run(4'h4, 11'h7FF, 0); chk("R4 jump bank1", 12'hFFF);
        run(4'h1, 0, 0); chk("R2 wrap keeps bank1", 12'h800);
    endtask

    task automatic t_arm();
        run(4'h2, 0, 0); chk("R3 arm0 no move", 12'h800);
        run(4'h4, 11'h010, 0); chk("R4 jump uses cleared flag", 12'h010);
        run(4'h3, 0, 0); chk("R3 arm1 no move", 12'h010);
        run(4'h4, 11'h020, 0); chk("R4 jump uses set flag", 12'h820);
        run(4'h0, 0, 0); chk("R12 hold", 12'h820);
        run(4'hC, 11'h7AA, 1); chk("R12 unused code", 12'h820);
    endtask

    task automatic t_call_ret();
        run(4'h2, 0, 0);
        run(4'h5, 11'h100, 0); chk("R5 call bank0", 12'h100);
        run(4'h3, 0, 0);
        run(4'h6, 0, 0); chk("R6 return restores bit 11", 12'h821);
        run(4'h4, 11'h005, 0); chk("R6 flag kept over return", 12'h805);
    endtask

    task automatic t_irq();
        run(4'h8, 0, 1); chk("R7 vector 7", 12'h007);
        run(4'h3, 0, 0);
        run(4'h4, 11'h050, 0); chk("R8 jump in service stays bank0", 12'h050);
        run(4'h5, 11'h060, 0); chk("R8 call in service stays bank0", 12'h060);
        run(4'h6, 0, 0); chk("R5 return inside service", 12'h051);
        run(4'h8, 0, 0); chk("R9 nested entry ignored", 12'h051);
        run(4'h7, 0, 0); chk("R10 reti restores", 12'h805);
        run(4'h4, 11'h060, 0); chk("R10 R8 bank flag reaches jump after service", 12'h860);
        run(4'h8, 0, 0); chk("R7 vector 3", 12'h003);
        run(4'h7, 0, 0); chk("R10 reti restores bank1", 12'h860);
    endtask

    task automatic t_stack();
        run(4'h2, 0, 0);
        run(4'h4, 11'h000, 0);
        for (int i = 0; i < 9; i++) begin
            run(4'h5, 11'((i + 1) * 16), 0);
        end
        chk("R5 ninth call target", 12'h090);
        for (int i = 8; i >= 1; i--) begin
            run(4'h6, 0, 0); chk("R11 pop order", 12'(i * 16 + 1));
        end
        run(4'h6, 0, 0); chk("R11 wrap after eight pops", 12'h081);
    endtask

    task automatic t_reset_mid();
        run(4'h3, 0, 0);
        run(4'h8, 0, 1);
        do_reset();
        chk("R1 reset mid service", 12'h000);
        run(4'h8, 0, 0); chk("R1 service cleared, entry taken", 12'h003);
        run(4'h7, 0, 0);
        run(4'h4, 11'h030, 0); chk("R1 flag cleared by reset", 12'h030);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_step();
        t_arm();
        t_call_ret();
        t_irq();
        t_stack();
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule